// File: doc/BRIEF.md
# Enhanced Idle State Sequencer

This controller moves a processor package between its running state and four idle states: Stop-Grant, Sleep, Deep Sleep and Deeper Sleep. An idle request carries a state code and a sub-state hint. When the hint is set, or when a per-state promotion bit in the configuration is set, the request takes its enhanced form. In that form the controller first asks an external voltage and frequency stepper to drop the performance point to the lowest level. Only after the stepper acknowledges does it enter the idle state. In every enhanced idle state the power-down enable is held on.

A break event ends residency. The controller signals resume at once, and in the enhanced case the step back to the saved performance point runs in parallel. Steps take time, so new idle requests that arrive during an upward step are accepted and redirect or follow the step in flight. A break that arrives before a step-down completes cancels the entry.

Clocks are stopped in Sleep, Deep Sleep and Deeper Sleep, so no step may run there. There is one exception: an enhanced Deeper Sleep entered with the hard deep-state option set. In that state the controller issues a voltage-lowering step while resident. On exit it steps to the lowest point first, instead of going back to the saved point.

Top module: `idle_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, the outputs are as follows: `pkg_state` = 0 (Active), `pkg_enh` = 0, `perf_tgt` = 0, `step_req` = 0, `clk_active` = 1, `resume` = 0 and `pwrdn_en` = 0.
- R2: State codes are Active = 0, Stop-Grant = 1, Sleep = 2, Deep Sleep = 3 and Deeper Sleep = 4. A plain request with a code from 1 to 4, accepted while Active, shows that code on `pkg_state` after the next edge. `perf_tgt` is unchanged and no step is requested.
- R3: `clk_active` is 0 exactly when `pkg_state` is 2, 3 or 4.
- R4: A request is enhanced when `idle_hint` is 1, or when bit (code-1) of `cfg_promote` is 1.
- R5: An enhanced request accepted while Active keeps `pkg_state` at Active. After the next edge it sets `perf_tgt` to 0 and raises `step_req`. The idle state, with `pkg_enh` = 1, appears only on the edge that samples `step_ack`.
- R6: A break while resident returns `pkg_state` to 0 on the next edge, with a one-cycle `resume` pulse. After an enhanced state other than hard Deeper Sleep, `perf_tgt` takes the saved point and `step_req` rises on the same edge.
- R7: `step_req` stays high until an edge samples `step_ack`. It is never high while `clk_active` is 0, except during residency in enhanced Deeper Sleep with the hard option.
- R8: An enhanced Deeper Sleep request made with `cfg_hard_deep` = 1 enters with `step_req` = 1 and `perf_tgt` = 0 while clocks are stopped. On a break it resumes with `perf_tgt` = 0 and a step request. After the acknowledge it goes back to following `perf_req`.
- R9: A break during a pending step-down cancels the entry. `pkg_state` stays 0, `resume` stays 0, `perf_tgt` returns to the saved point and `step_req` remains high.
- R10: A valid request during the upward step is accepted. An enhanced one retargets the step to 0. A plain one enters on the step's acknowledge, which may be in the same cycle. The saved point is kept.
- R11: The following have no effect: codes 0, 5, 6 and 7, requests while resident or while a step-down is pending, breaks outside residency and the step-down window, and acknowledges with no step pending.
- R12: While Active with no step in flight, `perf_tgt` equals `perf_req` one edge later.
- R13: `pwrdn_en` is 1 exactly while resident in an enhanced idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Idle request strobe |
| idle_code | input | 3 | Target idle state code |
| idle_hint | input | 1 | Sub-state hint asking for the enhanced form |
| cfg_promote | input | NUM_IDLE | Per-state automatic promotion bits |
| cfg_hard_deep | input | 1 | Hard deep-state option for Deeper Sleep |
| perf_req | input | PERF_W | Software performance point |
| brk_evt | input | 1 | Break event strobe |
| step_ack | input | 1 | Step done pulse from the stepper |
| pkg_state | output | 3 | Current package state code |
| pkg_enh | output | 1 | Enhanced variant flag |
| perf_tgt | output | PERF_W | Performance-point target to the stepper |
| step_req | output | 1 | Step request, held until acknowledged |
| clk_active | output | 1 | Package clocks running |
| resume | output | 1 | One-cycle pulse on return of control |
| pwrdn_en | output | 1 | Power-down feature enable |

## Verification
Every output is registered, so every result is due on the first clock edge that samples the stimulus. The only exception is idle entry after a step-down, which is due on the edge that samples the acknowledge. The bench drives inputs on the falling edge and advances its reference model at the following rising edge. It then compares all outputs at the next falling edge, which is one full cycle after each stimulus. Directed sequences pin down the ordering cases: cancel, retarget, acknowledge coinciding with a request or a break, and hard Deeper Sleep. A long pseudo-random run follows, with acknowledges arriving at arbitrary times.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PK_ACTIVE  = 3'd0,
    PK_STOPGNT = 3'd1,
    PK_SLEEP   = 3'd2,
    PK_DEEP    = 3'd3,
    PK_DEEPER  = 3'd4
  } pkg_state_e;

  typedef enum logic [2:0] {
    PH_RUN,
    PH_ENTER,
    PH_RESIDENT,
    PH_RAMPUP,
    PH_HARDEXIT
  } phase_e;
endpackage

// File: rtl/isc_req_decode.sv
module isc_req_decode
  import isc_pkg::*;
#(
  parameter int NUM_IDLE = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              hint,
  input  logic [NUM_IDLE-1:0] promote,
  input  logic              hard_cfg,
  output logic              valid,
  output logic              enh,
  output logic              hard
);
  logic [NUM_IDLE-1:0] hit;
  logic [NUM_IDLE-1:0] prom_hit;

  // one comparator per idle state code (codes 1..NUM_IDLE)
  for (genvar gi = 0; gi < NUM_IDLE; gi++) begin : g_code
    assign hit[gi]      = (code == CODE_W'(gi + 1));
    assign prom_hit[gi] = hit[gi] & promote[gi];
  end

  assign valid = |hit;
  assign enh   = valid & (hint | (|prom_hit));
  assign hard  = enh & hard_cfg & (code == PK_DEEPER);
endmodule

// File: rtl/isc_state_attr.sv
module isc_state_attr
  import isc_pkg::*;
#(
  parameter logic [7:0] STOP_MASK = 8'b0001_1100
) (
  input  logic [CODE_W-1:0] code,
  output logic              clk_stop
);
  logic [7:0] sel;

  for (genvar gi = 0; gi < 8; gi++) begin : g_sel
    assign sel[gi] = (code == CODE_W'(gi)) & STOP_MASK[gi];
  end

  assign clk_stop = |sel;
endmodule

// File: rtl/isc_seq_core.sv
module isc_seq_core
  import isc_pkg::*;
#(
  parameter int PERF_W = 4,
  parameter int LOW_PT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_ok,
  input  logic              req_enh,
  input  logic              req_hard,
  input  logic [PERF_W-1:0] perf_req,
  input  logic              brk_evt,
  input  logic              step_ack,
  input  logic              entry_stop,
  output logic [CODE_W-1:0] entry_code,
  output logic [CODE_W-1:0] pkg_state,
  output logic              pkg_enh,
  output logic [PERF_W-1:0] perf_tgt,
  output logic              step_req,
  output logic              clk_active,
  output logic              resume,
  output logic              pwrdn_en
);
  localparam logic [PERF_W-1:0] LOW = PERF_W'(LOW_PT);

  phase_e              ph;
  logic [CODE_W-1:0]   pend_code;
  logic                pend_enh;
  logic                pend_hard;
  logic                hard_r;
  logic [PERF_W-1:0]   saved;
  logic                take;

  assign take       = idle_req & req_ok;
  assign entry_code = (ph == PH_ENTER) ? pend_code : req_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_RUN;
      pkg_state  <= PK_ACTIVE;
      pkg_enh    <= 1'b0;
      perf_tgt   <= LOW;
      step_req   <= 1'b0;
      clk_active <= 1'b1;
      resume     <= 1'b0;
      pwrdn_en   <= 1'b0;
      saved      <= LOW;
      pend_code  <= PK_ACTIVE;
      pend_enh   <= 1'b0;
      pend_hard  <= 1'b0;
      hard_r     <= 1'b0;
    end else begin
      resume <= 1'b0;
      unique case (ph)
        PH_RUN: begin
          perf_tgt <= perf_req;
          if (take) begin
            saved <= perf_tgt;
            if (req_enh) begin
              perf_tgt  <= LOW;
              step_req  <= 1'b1;
              pend_code <= req_code;
              pend_enh  <= 1'b1;
              pend_hard <= req_hard;
              ph        <= PH_ENTER;
            end else begin
              perf_tgt   <= perf_tgt;
              pkg_state  <= req_code;
              pkg_enh    <= 1'b0;
              pwrdn_en   <= 1'b0;
              clk_active <= ~entry_stop;
              hard_r     <= 1'b0;
              ph         <= PH_RESIDENT;
            end
          end
        end
        PH_ENTER: begin
          if (brk_evt) begin
            perf_tgt <= saved;
            step_req <= 1'b1;
            ph       <= PH_RAMPUP;
          end else if (step_ack) begin
            pkg_state  <= pend_code;
            pkg_enh    <= pend_enh;
            pwrdn_en   <= pend_enh;
            clk_active <= ~entry_stop;
            hard_r     <= pend_hard;
            step_req   <= pend_hard;
            ph         <= PH_RESIDENT;
          end
        end
        PH_RESIDENT: begin
          if (step_req && step_ack) step_req <= 1'b0;
          if (brk_evt) begin
            pkg_state  <= PK_ACTIVE;
            pkg_enh    <= 1'b0;
            pwrdn_en   <= 1'b0;
            clk_active <= 1'b1;
            resume     <= 1'b1;
            hard_r     <= 1'b0;
            if (hard_r) begin
              perf_tgt <= LOW;
              step_req <= 1'b1;
              ph       <= PH_HARDEXIT;
            end else if (pkg_enh) begin
              perf_tgt <= saved;
              step_req <= 1'b1;
              ph       <= PH_RAMPUP;
            end else begin
              ph <= PH_RUN;
            end
          end
        end
        PH_RAMPUP: begin
          if (take) begin
            if (req_enh) begin
              perf_tgt  <= LOW;
              step_req  <= 1'b1;
              pend_code <= req_code;
              pend_enh  <= 1'b1;
              pend_hard <= req_hard;
              ph        <= PH_ENTER;
            end else if (step_ack) begin
              step_req   <= 1'b0;
              pkg_state  <= req_code;
              pkg_enh    <= 1'b0;
              pwrdn_en   <= 1'b0;
              clk_active <= ~entry_stop;
              hard_r     <= 1'b0;
              ph         <= PH_RESIDENT;
            end else begin
              pend_code <= req_code;
              pend_enh  <= 1'b0;
              pend_hard <= 1'b0;
              ph        <= PH_ENTER;
            end
          end else if (step_ack) begin
            step_req <= 1'b0;
            ph       <= PH_RUN;
          end
        end
        PH_HARDEXIT: begin
          if (step_ack) begin
            step_req <= 1'b0;
            ph       <= PH_RUN;
          end
        end
        default: ph <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
  import isc_pkg::*;
#(
  parameter int         PERF_W    = 4,
  parameter int         NUM_IDLE  = 4,
  parameter int         LOW_PT    = 0,
  parameter logic [7:0] STOP_MASK = 8'b0001_1100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle_req,
  input  logic [2:0]          idle_code,
  input  logic                idle_hint,
  input  logic [NUM_IDLE-1:0] cfg_promote,
  input  logic                cfg_hard_deep,
  input  logic [PERF_W-1:0]   perf_req,
  input  logic                brk_evt,
  input  logic                step_ack,
  output logic [2:0]          pkg_state,
  output logic                pkg_enh,
  output logic [PERF_W-1:0]   perf_tgt,
  output logic                step_req,
  output logic                clk_active,
  output logic                resume,
  output logic                pwrdn_en
);
  logic              req_ok;
  logic              req_enh;
  logic              req_hard;
  logic              entry_stop;
  logic [CODE_W-1:0] entry_code;

  isc_req_decode #(.NUM_IDLE(NUM_IDLE)) u_dec (
    .code     (idle_code),
    .hint     (idle_hint),
    .promote  (cfg_promote),
    .hard_cfg (cfg_hard_deep),
    .valid    (req_ok),
    .enh      (req_enh),
    .hard     (req_hard)
  );

  isc_state_attr #(.STOP_MASK(STOP_MASK)) u_attr (
    .code     (entry_code),
    .clk_stop (entry_stop)
  );

  isc_seq_core #(.PERF_W(PERF_W), .LOW_PT(LOW_PT)) u_core (
    .clk        (clk),
    .rst        (rst),
    .idle_req   (idle_req),
    .req_code   (idle_code),
    .req_ok     (req_ok),
    .req_enh    (req_enh),
    .req_hard   (req_hard),
    .perf_req   (perf_req),
    .brk_evt    (brk_evt),
    .step_ack   (step_ack),
    .entry_stop (entry_stop),
    .entry_code (entry_code),
    .pkg_state  (pkg_state),
    .pkg_enh    (pkg_enh),
    .perf_tgt   (perf_tgt),
    .step_req   (step_req),
    .clk_active (clk_active),
    .resume     (resume),
    .pwrdn_en   (pwrdn_en)
  );
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int PERF_W = 4,
  parameter int LOW_PT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        pkg_state,
  input logic              pkg_enh,
  input logic [PERF_W-1:0] perf_tgt,
  input logic              step_req,
  input logic              step_ack,
  input logic              clk_active,
  input logic              resume,
  input logic              pwrdn_en
);
  AST_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
    step_req && !step_ack |=> step_req); // R7

  AST_NO_STEP_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    step_req && !clk_active |-> pkg_enh && pkg_state == 3'd4); // R7

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume); // R6

  AST_RESUME_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    resume |-> pkg_state == 3'd0 && $past(pkg_state) != 3'd0); // R6

  AST_ENH_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(pkg_enh) |-> $past(step_ack) && perf_tgt == PERF_W'(LOW_PT)); // R5

  AST_PWRDN_ENH: assert property (@(posedge clk) disable iff (rst)
    pkg_enh |-> pwrdn_en && pkg_state != 3'd0); // R13

  AST_CLK_RUN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    pkg_state == 3'd0 |-> clk_active); // R3
endmodule

bind idle_seq_ctrl isc_checker #(.PERF_W(PERF_W), .LOW_PT(LOW_PT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pkg_state  (pkg_state),
  .pkg_enh    (pkg_enh),
  .perf_tgt   (perf_tgt),
  .step_req   (step_req),
  .step_ack   (step_ack),
  .clk_active (clk_active),
  .resume     (resume),
  .pwrdn_en   (pwrdn_en)
);

// File: tb/tb_idle_seq_ctrl.sv
module tb_idle_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 60000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idle_req = 1'b0;
  logic [2:0] idle_code = 3'd0;
  logic       idle_hint = 1'b0;
  logic [3:0] cfg_promote = 4'd0;
  logic       cfg_hard_deep = 1'b0;
  logic [3:0] perf_req = 4'd0;
  logic       brk_evt = 1'b0;
  logic       step_ack = 1'b0;
  logic [2:0] pkg_state;
  logic       pkg_enh;
  logic [3:0] perf_tgt;
  logic       step_req;
  logic       clk_active;
  logic       resume;
  logic       pwrdn_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_mode = 0; // 0 run, 1 entering, 2 resident, 3 ramping up, 4 hard exit
  int m_state = 0, m_perf = 0, m_saved = 0, m_pcode = 0;
  bit m_enh = 0, m_step = 0, m_res = 0, m_pd = 0, m_hard = 0, m_penh = 0, m_phard = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_seq_ctrl dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .idle_code(idle_code),
    .idle_hint(idle_hint), .cfg_promote(cfg_promote), .cfg_hard_deep(cfg_hard_deep),
    .perf_req(perf_req), .brk_evt(brk_evt), .step_ack(step_ack),
    .pkg_state(pkg_state), .pkg_enh(pkg_enh), .perf_tgt(perf_tgt),
    .step_req(step_req), .clk_active(clk_active), .resume(resume), .pwrdn_en(pwrdn_en)
  );

  task automatic go_idle(input int c, input bit e, input bit h);
    m_state = c; m_enh = e; m_pd = e; m_hard = h; m_step = h; m_mode = 2;
  endtask

  task automatic model_step();
    int  c;
    bit  ok, enh, hard, was_enh;
    c    = int'(idle_code);
    ok   = (c >= 1) && (c <= 4);
    enh  = ok && (idle_hint || cfg_promote[(c + 3) % 4]);
    hard = enh && cfg_hard_deep && (c == 4);
    m_res = 0;
    if (rst) begin
      m_mode = 0; m_state = 0; m_perf = 0; m_saved = 0; m_enh = 0;
      m_step = 0; m_pd = 0; m_hard = 0;
      return;
    end
    case (m_mode)
      0: begin
        if (idle_req && ok) begin
          m_saved = m_perf;
          if (enh) begin
            m_perf = 0; m_step = 1; m_pcode = c; m_penh = 1; m_phard = hard; m_mode = 1;
          end else go_idle(c, 0, 0);
        end else m_perf = int'(perf_req);
      end
      1: begin
        if (brk_evt) begin m_perf = m_saved; m_step = 1; m_mode = 3; end
        else if (step_ack) go_idle(m_pcode, m_penh, m_phard);
      end
      2: begin
        if (m_step && step_ack) m_step = 0;
        if (brk_evt) begin
          was_enh = m_enh;
          m_res = 1; m_state = 0; m_enh = 0; m_pd = 0;
          if (m_hard) begin m_perf = 0; m_step = 1; m_mode = 4; end
          else if (was_enh) begin m_perf = m_saved; m_step = 1; m_mode = 3; end
          else m_mode = 0;
          m_hard = 0;
        end
      end
      3: begin
        if (idle_req && ok) begin
          if (enh) begin
            m_perf = 0; m_step = 1; m_pcode = c; m_penh = 1; m_phard = hard; m_mode = 1;
          end else if (step_ack) go_idle(c, 0, 0);
          else begin m_pcode = c; m_penh = 0; m_phard = 0; m_mode = 1; end
        end else if (step_ack) begin m_step = 0; m_mode = 0; end
      end
      default: begin
        if (step_ack) begin m_step = 0; m_mode = 0; end
      end
    endcase
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "pkg_state(R2)", int'(pkg_state), m_state);
    chk(tag, "pkg_enh(R5)", int'(pkg_enh), int'(m_enh));
    chk(tag, "perf_tgt(R12)", int'(perf_tgt), m_perf);
    chk(tag, "step_req(R7)", int'(step_req), int'(m_step));
    chk(tag, "clk_active(R3)", int'(clk_active), (m_state >= 2 && m_state <= 4) ? 0 : 1);
    chk(tag, "resume(R6)", int'(resume), int'(m_res));
    chk(tag, "pwrdn_en(R13)", int'(pwrdn_en), int'(m_pd));
  endtask

  task automatic cyc(input string tag, input bit rq, input int code, input bit hint,
                     input bit brk, input bit ack);
    idle_req  = rq;
    idle_code = code[2:0];
    idle_hint = hint;
    brk_evt   = brk;
    step_ack  = ack;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_n(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    idle_n("R1_reset", 3);
    rst = 1'b0;
    idle_n("R1_after", 1);

    // R12: target follows software point
    perf_req = 4'd5;
    idle_n("R12_track", 2);
    perf_req = 4'd9;
    idle_n("R12_track2", 2);

    // R2: plain Stop-Grant, then break (R6 plain resume)
    cyc("R2_sg_entry", 1, 1, 0, 0, 0);
    idle_n("R2_sg_stay", 2);
    cyc("R6_sg_exit", 0, 0, 0, 1, 0);
    idle_n("R6_after", 1);

    // R3: plain Sleep and Deep Sleep stop clocks
    cyc("R3_sleep", 1, 2, 0, 0, 0);
    cyc("R11_ack_idle", 0, 0, 0, 0, 1);
    cyc("R3_exit", 0, 0, 0, 1, 0);
    cyc("R3_deep", 1, 3, 0, 0, 0);
    cyc("R3_exit2", 0, 0, 0, 1, 0);

    // R5: enhanced via hint, step down first, enter on ack
    perf_req = 4'd12;
    idle_n("R12_pre", 1);
    cyc("R5_req", 1, 3, 1, 0, 0);
    idle_n("R5_wait", 3);
    cyc("R5_ack", 0, 0, 0, 0, 1);
    idle_n("R13_res", 2);
    cyc("R6_brk", 0, 0, 0, 1, 0);
    idle_n("R6_rampup", 2);
    cyc("R6_ack", 0, 0, 0, 0, 1);
    idle_n("R12_back", 2);

    // R4: promotion bit for Sleep (bit 1), no hint
    cfg_promote = 4'b0010;
    cyc("R4_prom", 1, 2, 0, 0, 0);
    cyc("R4_ack", 0, 0, 0, 0, 1);
    cyc("R4_brk", 0, 0, 0, 1, 0);
    cyc("R4_ack2", 0, 0, 0, 0, 1);
    cyc("R4_noprom", 1, 1, 0, 0, 0); // Stop-Grant not promoted
    cyc("R4_exit", 0, 0, 0, 1, 0);
    cfg_promote = 4'b0000;

    // R9: break during pending step-down cancels
    perf_req = 4'd7;
    idle_n("R9_pre", 1);
    cyc("R9_req", 1, 1, 1, 0, 0);
    cyc("R9_brk", 0, 0, 0, 1, 0);
    idle_n("R9_hold", 2);
    cyc("R9_ack", 0, 0, 0, 0, 1);
    cyc("R9_brkack", 1, 2, 1, 0, 0);
    cyc("R9_brk_and_ack", 0, 0, 0, 1, 1);
    cyc("R9_ack3", 0, 0, 0, 0, 1);

    // R10: requests during upward step
    cyc("R10_a", 1, 3, 1, 0, 0);
    cyc("R10_a_ack", 0, 0, 0, 0, 1);
    cyc("R10_a_brk", 0, 0, 0, 1, 0);
    cyc("R10_retarget", 1, 2, 1, 0, 0);
    cyc("R10_retgt_ack", 0, 0, 0, 0, 1);
    cyc("R10_b_brk", 0, 0, 0, 1, 0);
    cyc("R10_plain_pend", 1, 1, 0, 0, 0);
    idle_n("R10_pend_wait", 1);
    cyc("R10_pend_ack", 0, 0, 0, 0, 1);
    cyc("R10_plain_exit", 0, 0, 0, 1, 0);
    cyc("R10_c", 1, 4, 1, 0, 0);
    cyc("R10_c_ack", 0, 0, 0, 0, 1);
    cyc("R10_c_brk", 0, 0, 0, 1, 0);
    cyc("R10_plain_ack_same", 1, 2, 0, 0, 1);
    cyc("R10_exit", 0, 0, 0, 1, 0);

    // R8: hard Deeper Sleep
    cfg_hard_deep = 1'b1;
    perf_req = 4'd11;
    idle_n("R8_pre", 1);
    cyc("R8_req", 1, 4, 1, 0, 0);
    cyc("R8_ack_dn", 0, 0, 0, 0, 1);
    idle_n("R8_vlow", 2);
    cyc("R8_vlow_ack", 0, 0, 0, 0, 1);
    cyc("R8_brk", 0, 0, 0, 1, 0);
    idle_n("R8_hx", 1);
    cyc("R8_hx_ack", 0, 0, 0, 0, 1);
    idle_n("R8_track", 2);
    cyc("R8_req2", 1, 4, 1, 0, 0);
    cyc("R8_ack2", 0, 0, 0, 0, 1);
    cyc("R8_brk_early", 0, 0, 0, 1, 0);
    cyc("R8_hx_ack2", 0, 0, 0, 0, 1);
    cyc("R8_sleep_nohard", 1, 3, 1, 0, 0); // hard applies only to Deeper
    cyc("R8_sleep_ack", 0, 0, 0, 0, 1);
    cyc("R8_sleep_brk", 0, 0, 0, 1, 0);
    cyc("R8_sleep_up", 0, 0, 0, 0, 1);
    cfg_hard_deep = 1'b0;
    cyc("R8_soft", 1, 4, 1, 0, 0);
    cyc("R8_soft_ack", 0, 0, 0, 0, 1);
    cyc("R8_soft_brk", 0, 0, 0, 1, 0);
    cyc("R8_soft_up", 0, 0, 0, 0, 1);

    // R11: ignored stimuli
    cyc("R11_code0", 1, 0, 1, 0, 0);
    cyc("R11_code6", 1, 6, 1, 0, 0);
    cyc("R11_code7", 1, 7, 0, 0, 0);
    cyc("R11_brk_run", 0, 0, 0, 1, 0);
    cyc("R11_ack_run", 0, 0, 0, 0, 1);
    cyc("R11_enter", 1, 2, 0, 0, 0);
    cyc("R11_req_res", 1, 3, 1, 0, 0);
    cyc("R11_exit", 0, 0, 0, 1, 0);
    cyc("R11_enh", 1, 1, 1, 0, 0);
    cyc("R11_req_pend", 1, 4, 0, 0, 0);
    cyc("R11_enh_ack", 0, 0, 0, 0, 1);
    cyc("R11_enh_brk", 0, 0, 0, 1, 0);
    cyc("R11_brk_ramp", 0, 0, 0, 1, 0);
    cyc("R11_ramp_ack", 0, 0, 0, 0, 1);

    // R7: pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) cfg_promote = 4'($urandom);
      if (i % 131 == 0) cfg_hard_deep = 1'($urandom);
      if (i % 5 == 0) perf_req = 4'($urandom);
      cyc("R7_rand", ($urandom % 4) == 0, int'($urandom % 8), ($urandom % 2) == 0,
          ($urandom % 6) == 0, step_req ? (($urandom % 3) == 0) : (($urandom % 10) == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule